// File: doc/BRIEF.md
# Command Phase Byte Sequencer

This block runs the host-facing command phase of a floppy disk controller. While in this phase it advertises, through a ready flag (`rqm`) and a direction flag (`dio`), when the host may write the next byte. It takes the opcode byte first and looks up how many parameter bytes that opcode needs. It then collects the parameters one at a time. After each accepted byte it withholds the ready flag for a fixed processing delay.

Once the last byte of a legal command has arrived, the block enters the execution phase and emits a single-cycle start pulse. The collected bytes are presented to the execution logic in arrival order. An opcode that is not in the table is refused: the block raises an invalid-command flag, turns the direction flag toward the host, and offers one status byte to read. Reading that byte puts the block back into the command phase.

The data FIFO is kept bypassed for the whole command phase, so a refused command never leaves stray bytes queued.

Top module: `cmd_phase_seq`

## Requirements
- R1: After synchronous reset the block is in the command phase, ready for an opcode: `rqm`=1, `dio`=0, `fifo_bypass`=1, `invalid_cmd`=0, `exec_start`=0, `cmd_len`=0.
- R2: A byte is accepted on a rising edge where `host_wr`=1, `rqm`=1 and `dio`=0. The n-th accepted byte of a command (opcode is n=0) is stored in `cmd_bytes[8n+7:8n]`, and `cmd_len` counts the accepted bytes.
- R3: In the two clock cycles that follow an accepted write, `rqm` reads 0.
- R4: When further parameter bytes are still owed, `rqm` returns to 1 (with `dio`=0) in the third cycle after the accepted write (`PROC_LAT`=2 cycles of processing).
- R5: After the final byte of a legal command, `rqm` stays 0 and `exec_start` is 1 for exactly one cycle, the third cycle after that write. `cmd_len` then equals 1 plus the opcode's parameter count.
- R6: The parameter count comes from bits [4:0] of the opcode, and bits [7:5] do not affect it. The legal opcodes are 0x08 (0 parameters), 0x04, 0x07 and 0x0A (1 each), 0x03 and 0x0F (2 each), 0x0D (5), and 0x05 and 0x06 (8 each).
- R7: Any other value of bits [4:0] is refused. In the third cycle after the opcode write, `invalid_cmd`=1, `rqm`=1, `dio`=1 and `status_byte`=0x80, and no `exec_start` is issued. A one-cycle `host_rd` pulse then returns the block to the command phase with `invalid_cmd`=0 and `cmd_len`=0.
- R8: `fifo_bypass` is 1 in every command-phase state (awaiting a byte, processing, refused) and 0 during the execution phase.
- R9: A write presented while `rqm`=0 (processing or execution), or while `dio`=1 (refused), is ignored: `cmd_len` and the stored bytes are unchanged.
- R10: A one-cycle `exec_done` pulse during the execution phase returns the block to the command phase with `rqm`=1, `dio`=0 and `cmd_len`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe for the refusal status byte |
| exec_done | input | 1 | Execution logic finished; return to the command phase |
| rqm | output | 1 | Ready flag: host may transfer a byte |
| dio | output | 1 | Direction flag: 1 means controller-to-host |
| fifo_bypass | output | 1 | FIFO bypassed while in the command phase |
| status_byte | output | 8 | Status offered to the host after a refused opcode |
| cmd_bytes | output | MAX_BYTES*8 | Collected bytes, opcode in the lowest byte |
| cmd_len | output | LEN_W | Number of bytes collected for the current command |
| exec_start | output | 1 | One-cycle pulse entering the execution phase |
| invalid_cmd | output | 1 | Refused-opcode flag |

## Verification
The bench builds the block with its default nine byte slots and a two-cycle processing delay. The nine slots let an eight-parameter opcode fill every slot, including the top one, so the upper storage bound is exercised. With a two-cycle delay, the low window of the ready flag and the cycle in which it returns or the start pulse fires are both short and exact, so each can be sampled cycle by cycle. Writes are injected inside the processing window and during the refused state to show that they are dropped.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        PH_TAKE   = 2'd0,
        PH_DIGEST = 2'd1,
        PH_REFUSE = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    typedef struct packed {
        logic       known;
        logic [3:0] extra;
    } opinfo_t;

    localparam logic [7:0] REFUSE_STATUS = 8'h80;

    function automatic opinfo_t lookup_opcode(input logic [4:0] code);
        opinfo_t r;
        r.known = 1'b1;
        case (code)
            5'h08:   r.extra = 4'd0;
            5'h04:   r.extra = 4'd1;
            5'h07:   r.extra = 4'd1;
            5'h0A:   r.extra = 4'd1;
            5'h03:   r.extra = 4'd2;
            5'h0F:   r.extra = 4'd2;
            5'h0D:   r.extra = 4'd5;
            5'h05:   r.extra = 4'd8;
            5'h06:   r.extra = 4'd8;
            default: begin
                r.known = 1'b0;
                r.extra = 4'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cps_opdecode.sv
module cps_opdecode
    import cps_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [4:0]       code,
    output logic             known,
    output logic [LEN_W-1:0] total
);
    opinfo_t info;

    always_comb begin
        info  = lookup_opcode(code);
        known = info.known;
        total = LEN_W'(info.extra) + LEN_W'(1);
    end

    always_comb begin
        AST_TOTAL_NONZERO: assert (total != '0); // R6
    end
endmodule

// File: rtl/cps_digest_timer.sv
module cps_digest_timer #(
    parameter int PROC_LAT = 2,
    localparam int CW = $clog2(PROC_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= CW'(PROC_LAT - 1);
        end else if (act_q) begin
            if (cnt_q == '0) act_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = act_q;
    assign done = act_q && (cnt_q == '0);

    AST_TIMER_ARMS: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R4
    AST_TIMER_ENDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy); // R4
endmodule

// File: rtl/cps_slot_bank.sv
module cps_slot_bank #(
    parameter int MAX_BYTES = 9,
    parameter int LEN_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [LEN_W-1:0]       wr_idx,
    input  logic [7:0]             wr_byte,
    output logic [MAX_BYTES*8-1:0] flat
);
    logic [7:0] slot_q [MAX_BYTES];

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= 8'h00;
            else if (wr_en && (wr_idx == LEN_W'(g)))
                slot_q[g] <= wr_byte;
        end
        assign flat[g*8 +: 8] = slot_q[g];
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < LEN_W'(MAX_BYTES))); // R2
endmodule

// File: rtl/cmd_phase_seq.sv
module cmd_phase_seq
    import cps_pkg::*;
#(
    parameter int MAX_BYTES = 9,
    parameter int PROC_LAT = 2,
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_wr,
    input  logic [7:0]             host_wdata,
    input  logic                   host_rd,
    input  logic                   exec_done,
    output logic                   rqm,
    output logic                   dio,
    output logic                   fifo_bypass,
    output logic [7:0]             status_byte,
    output logic [MAX_BYTES*8-1:0] cmd_bytes,
    output logic [LEN_W-1:0]       cmd_len,
    output logic                   exec_start,
    output logic                   invalid_cmd
);
    phase_e           ph_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] need_q;
    logic             bad_q;
    logic             go_q;

    logic             take;
    logic             dec_known;
    logic [LEN_W-1:0] dec_total;
    logic             t_busy;
    logic             t_done;

    assign take = host_wr && (ph_q == PH_TAKE);

    cps_opdecode #(.LEN_W(LEN_W)) u_dec (
        .code  (host_wdata[4:0]),
        .known (dec_known),
        .total (dec_total)
    );

    cps_digest_timer #(.PROC_LAT(PROC_LAT)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (take),
        .busy  (t_busy),
        .done  (t_done)
    );

    cps_slot_bank #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_idx  (idx_q),
        .wr_byte (host_wdata),
        .flat    (cmd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_TAKE;
            idx_q  <= '0;
            need_q <= LEN_W'(1);
            bad_q  <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (ph_q)
                PH_TAKE: begin
                    if (take) begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (idx_q == '0) begin
                            need_q <= dec_total;
                            bad_q  <= !dec_known;
                        end
                        ph_q <= PH_DIGEST;
                    end
                end
                PH_DIGEST: begin
                    if (t_done) begin
                        if (bad_q) begin
                            ph_q <= PH_REFUSE;
                        end else if (idx_q == need_q) begin
                            ph_q <= PH_RUN;
                            go_q <= 1'b1;
                        end else begin
                            ph_q <= PH_TAKE;
                        end
                    end
                end
                PH_REFUSE: begin
                    if (host_rd) begin
                        ph_q  <= PH_TAKE;
                        idx_q <= '0;
                        bad_q <= 1'b0;
                    end
                end
                PH_RUN: begin
                    if (exec_done) begin
                        ph_q  <= PH_TAKE;
                        idx_q <= '0;
                    end
                end
                default: ph_q <= PH_TAKE;
            endcase
        end
    end

    always_comb begin
        rqm         = (ph_q == PH_TAKE) || (ph_q == PH_REFUSE);
        dio         = (ph_q == PH_REFUSE);
        fifo_bypass = (ph_q != PH_RUN);
        invalid_cmd = (ph_q == PH_REFUSE);
        status_byte = (ph_q == PH_REFUSE) ? REFUSE_STATUS : 8'h00;
    end

    assign cmd_len    = idx_q;
    assign exec_start = go_q;

    AST_RQM_DROPS: assert property (@(posedge clk) disable iff (rst)
        (rqm && !dio && host_wr) |=> !rqm); // R3
    AST_DIGEST_WAITS: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DIGEST) |-> t_busy); // R3
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        exec_start |=> !exec_start); // R5
    AST_GO_QUIET: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> (!rqm && !invalid_cmd)); // R5
    AST_REFUSE_VIEW: assert property (@(posedge clk) disable iff (rst)
        invalid_cmd |-> (rqm && dio && status_byte == REFUSE_STATUS)); // R7
    AST_FIFO_CMD: assert property (@(posedge clk) disable iff (rst)
        rqm |-> fifo_bypass); // R8
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rqm && !exec_done) |=> $stable(cmd_len)); // R9
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        cmd_len <= LEN_W'(MAX_BYTES)); // R2
endmodule

// File: tb/sim_cmd_phase_seq.sv
module sim_cmd_phase_seq;
    localparam int NB = 9;
    localparam int LW = $clog2(NB + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic            host_wr = 1'b0;
    logic [7:0]      host_wdata = 8'h00;
    logic            host_rd = 1'b0;
    logic            exec_done = 1'b0;
    logic            rqm, dio, fifo_bypass, exec_start, invalid_cmd;
    logic [7:0]      status_byte;
    logic [NB*8-1:0] cmd_bytes;
    logic [LW-1:0]   cmd_len;

    int  total = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    cmd_phase_seq #(.MAX_BYTES(NB), .PROC_LAT(2)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .exec_done(exec_done), .rqm(rqm), .dio(dio),
        .fifo_bypass(fifo_bypass), .status_byte(status_byte),
        .cmd_bytes(cmd_bytes), .cmd_len(cmd_len), .exec_start(exec_start),
        .invalid_cmd(invalid_cmd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!(rqm && !dio) && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // mode 0: more bytes owed, 1: final byte, 2: refused opcode
    task automatic put_byte(input logic [7:0] b, input int mode, input bit poke);
        wait_ready();
        host_wr = 1'b1;
        host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
        chk(rqm == 1'b0, "R3", "rqm first cycle after write", rqm, 0);
        if (poke) begin
            host_wr = 1'b1;
            host_wdata = 8'hEE;
        end
        @(negedge clk);
        host_wr = 1'b0;
        chk(rqm == 1'b0, "R3", "rqm second cycle after write", rqm, 0);
        @(negedge clk);
        if (mode == 0) begin
            chk(rqm == 1'b1 && dio == 1'b0, "R4", "rqm back for next byte", rqm, 1);
        end else if (mode == 1) begin
            chk(rqm == 1'b0, "R5", "rqm held after final byte", rqm, 0);
            chk(exec_start == 1'b1, "R5", "exec_start fires", exec_start, 1);
        end else begin
            chk(invalid_cmd == 1'b1, "R7", "invalid flag", invalid_cmd, 1);
            chk(rqm == 1'b1 && dio == 1'b1, "R7", "rqm/dio toward host", {rqm, dio}, 3);
            chk(status_byte == 8'h80, "R7", "status byte", status_byte, 8'h80);
            chk(exec_start == 1'b0, "R7", "no exec_start", exec_start, 0);
        end
    endtask

    task automatic run_cmd(input logic [7:0] seq[NB], input int n, input bit poke,
                           input string tag);
        for (int i = 0; i < n; i++)
            put_byte(seq[i], (i == n - 1) ? 1 : 0, poke);
        chk(int'(cmd_len) == n, "R5", {tag, " cmd_len"}, cmd_len, n);
        for (int i = 0; i < n; i++)
            chk(cmd_bytes[i*8 +: 8] == seq[i], "R2", {tag, " stored byte"},
                cmd_bytes[i*8 +: 8], seq[i]);
        chk(fifo_bypass == 1'b0, "R8", {tag, " fifo in execution"}, fifo_bypass, 0);
        @(negedge clk);
        chk(exec_start == 1'b0, "R5", {tag, " exec_start one cycle"}, exec_start, 0);
        chk(rqm == 1'b0, "R5", {tag, " rqm still low"}, rqm, 0);
        host_wr = 1'b1;
        host_wdata = 8'h55;
        @(negedge clk);
        host_wr = 1'b0;
        chk(int'(cmd_len) == n, "R9", {tag, " write in execution ignored"}, cmd_len, n);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        chk(rqm == 1'b1 && dio == 1'b0, "R10", {tag, " back to command"}, {rqm, dio}, 2);
        chk(cmd_len == '0, "R10", {tag, " cmd_len cleared"}, cmd_len, 0);
        chk(fifo_bypass == 1'b1, "R8", {tag, " fifo bypass in command"}, fifo_bypass, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rqm == 1'b1 && dio == 1'b0, "R1", "rqm/dio after reset", {rqm, dio}, 2);
        chk(fifo_bypass == 1'b1, "R1", "fifo_bypass after reset", fifo_bypass, 1);
        chk(invalid_cmd == 1'b0 && exec_start == 1'b0, "R1", "flags after reset",
            {invalid_cmd, exec_start}, 0);
        chk(cmd_len == '0, "R1", "cmd_len after reset", cmd_len, 0);
    endtask

    task automatic t_no_param();
        logic [7:0] s[NB] = '{8'h08, 0, 0, 0, 0, 0, 0, 0, 0};
        run_cmd(s, 1, 1'b0, "R6 opcode 0x08");
    endtask

    task automatic t_two_param_poke();
        logic [7:0] s[NB] = '{8'h03, 8'hA1, 8'h5C, 0, 0, 0, 0, 0, 0};
        run_cmd(s, 3, 1'b1, "R9 poke during digest");
    endtask

    task automatic t_one_param();
        logic [7:0] s[NB] = '{8'h0A, 8'h3C, 0, 0, 0, 0, 0, 0, 0};
        run_cmd(s, 2, 1'b0, "R6 opcode 0x0A");
    endtask

    task automatic t_five_param();
        logic [7:0] s[NB] = '{8'h0D, 8'h11, 8'h22, 8'h33, 8'h44, 8'h66, 0, 0, 0};
        run_cmd(s, 6, 1'b0, "R6 opcode 0x0D");
    endtask

    task automatic t_full_upper_bits();
        logic [7:0] s[NB] = '{8'hE6, 8'h01, 8'h02, 8'h03, 8'h04,
                              8'h05, 8'h06, 8'h07, 8'hF8};
        run_cmd(s, 9, 1'b0, "R6 opcode 0xE6 nine slots");
    endtask

    task automatic t_refused();
        put_byte(8'h1F, 2, 1'b0);
        chk(fifo_bypass == 1'b1, "R8", "fifo bypass while refused", fifo_bypass, 1);
        host_wr = 1'b1;
        host_wdata = 8'h08;
        @(negedge clk);
        host_wr = 1'b0;
        chk(cmd_len == LW'(1), "R9", "write while refused ignored", cmd_len, 1);
        chk(cmd_bytes[7:0] == 8'h1F, "R9", "opcode slot kept", cmd_bytes[7:0], 8'h1F);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(invalid_cmd == 1'b0, "R7", "flag cleared by read", invalid_cmd, 0);
        chk(rqm == 1'b1 && dio == 1'b0, "R7", "ready after read", {rqm, dio}, 2);
        chk(cmd_len == '0, "R7", "cmd_len after read", cmd_len, 0);
    endtask

    initial begin
        t_reset();
        t_no_param();
        t_two_param_poke();
        t_refused();
        t_one_param();
        t_five_param();
        t_full_upper_bits();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule